// File: doc/BRIEF.md
# Per-Function Three-Level Address Translation Walker

This block turns a guest device-physical address, issued on behalf of one virtual function, into a 48-bit host local-memory address. The translation tables are held in memory, and the block reads them one entry at a time. A base input gives the byte address of a per-function directory. The directory entry for the requesting function points to a mid-level table, which is indexed by the upper guest address bits. That mid-level entry points to a leaf table, which maps 2 MB host pages.

A requester presents a function number and a guest address with a valid/ready handshake. The walker then issues up to three reads on a single-outstanding memory read port. It ends the walk with a one-cycle response that carries either the host address or a fault with a code naming the failing stage. Only one walk is in progress at any time.

Top module: `vf_xlat_walker`

## Requirements
- R1: After reset, `reqReady` is 1 and `memReq` and `rspValid` are 0.
- R2: A request with function number 0 or 64 or more completes with `rspFault`=1 and `rspCode`=1, and no memory read is issued.
- R3: The first read targets `dirBase` + 8 x function number. If bit 0 of the returned entry is 0, the walk ends after that single read with `rspFault`=1 and `rspCode`=2.
- R4: The second read targets (directory entry bits 35:4) x 65536 + 8 x guest bits 47:35. Entry bits 3:1 and 63:36 are ignored. If bit 0 of this entry is 0, the walk ends after two reads with `rspCode`=3 and `rspFault`=1.
- R5: The third read targets (mid entry bits 35:4) x 65536 + 4 x guest bits 34:21. The leaf entry is taken from `memRdData[31:0]`, and bits 63:32 are ignored. If leaf bit 0 is 0, the walk ends after three reads with `rspCode`=4 and `rspFault`=1.
- R6: A walk in which all three entries are valid returns `rspFault`=0, `rspCode`=0 and `rspHpa` = {leaf bits 31:5, guest bits 20:0}. Leaf bits 4:1 are ignored. Exactly three reads are made, in the order directory, mid, leaf.
- R7: `memReq` stays high with a stable `memAddr` until the cycle in which `memReady` is high. The walker waits for `memRdValid` before it issues the next read.
- R8: `reqReady` goes low in the cycle after a request is accepted and stays low until the response. `rspValid` is high for exactly one cycle, and `reqReady` is high again in the following cycle. Request inputs that change during a walk do not affect its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dirBase | input | 48 | Byte address of the per-function directory |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and able to accept a request |
| reqVfId | input | 8 | Requesting function number |
| reqGpa | input | 48 | Guest address to translate |
| memReq | output | 1 | Table read request |
| memAddr | output | 48 | Byte address of the entry being read |
| memReady | input | 1 | Memory accepts the read this cycle |
| memRdValid | input | 1 | Read data returned this cycle |
| memRdData | input | 64 | Returned entry (a leaf entry is in bits 31:0) |
| rspValid | output | 1 | One-cycle result strobe |
| rspFault | output | 1 | Walk ended in a fault |
| rspCode | output | 3 | 0 ok, 1 bad function, 2 directory, 3 mid, 4 leaf |
| rspHpa | output | 48 | Translated host address, 0 on fault |

## Verification
Guest addresses are chosen so that the two upper index fields take the values zero, small nonzero and all-ones. This separates index-scaling and field-slicing errors, because the backing memory only answers at exact entry addresses. Each table entry is placed with its reserved bits set and with junk in the unused upper data half, so any mis-sliced pointer or page is detected. Separate walks end at each of the three stages and on function numbers 0, 64 and 200, and the number of reads per walk is compared against the stage reached. One walk runs with a stalling memory and with request inputs changed while busy, which tells a correct hold-and-ignore apart from an early advance.

// File: rtl/xw_pkg.sv
package xw_pkg;

  typedef enum logic [2:0] {
    FC_NONE   = 3'd0,
    FC_BAD_VF = 3'd1,
    FC_DIR    = 3'd2,
    FC_MID    = 3'd3,
    FC_LEAF   = 3'd4
  } faultCode_e;

  // strobes from the walk control to the datapath
  typedef struct packed {
    logic       capture;
    logic       loadPtr;
    logic       loadLeaf;
    logic       setFault;
    faultCode_e code;
    logic [1:0] level;
  } walkCtl_t;

  localparam logic [1:0] LVL_DIR  = 2'd2;
  localparam logic [1:0] LVL_MID  = 2'd1;
  localparam logic [1:0] LVL_LEAF = 2'd0;

endpackage

// File: rtl/vf_xlat_dp.sv
module vf_xlat_dp
  import xw_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int VFID_W     = 8,
  parameter int NUM_FN     = 64,
  parameter int DATA_W     = 64,
  parameter int PAGE_SH    = 21,
  parameter int MID_SH     = 35,
  parameter int PTR_SH     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  walkCtl_t          ctl,
  input  logic [ADDR_W-1:0] dirBase,
  input  logic [VFID_W-1:0] reqVfId,
  input  logic [ADDR_W-1:0] reqGpa,
  input  logic [DATA_W-1:0] memRdData,
  output logic              vfBad,
  output logic              entryValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              rspFault,
  output logic [2:0]        rspCode,
  output logic [ADDR_W-1:0] rspHpa
);

  localparam int PTR_W    = ADDR_W - PTR_SH;   // pointer field width
  localparam int PAGE_W   = ADDR_W - PAGE_SH;  // page number width
  localparam int PTR_LSB  = 4;
  localparam int PAGE_LSB = 5;

  logic [VFID_W-1:0] vfQ;
  logic [ADDR_W-1:0] gpaQ;
  logic [ADDR_W-1:0] baseQ;
  logic [ADDR_W-1:0] hpaQ;
  logic              faultQ;
  faultCode_e        codeQ;

  logic [ADDR_W-1:0] entryOff;
  logic [ADDR_W-1:0] nextBase;
  logic [ADDR_W-1:0] leafHpa;

  assign vfBad      = (reqVfId == '0) || (32'(reqVfId) >= 32'(NUM_FN));
  assign entryValid = memRdData[0];
  assign nextBase   = {memRdData[PTR_LSB +: PTR_W], {PTR_SH{1'b0}}};
  assign leafHpa    = {memRdData[PAGE_LSB +: PAGE_W], gpaQ[PAGE_SH-1:0]};

  // offset of the entry inside the table being read
  always_comb begin
    unique case (ctl.level)
      LVL_DIR:  entryOff = ADDR_W'(vfQ) << 3;
      LVL_MID:  entryOff = ADDR_W'(gpaQ[ADDR_W-1:MID_SH]) << 3;
      default:  entryOff = ADDR_W'(gpaQ[MID_SH-1:PAGE_SH]) << 2;
    endcase
  end

  assign memAddr = baseQ + entryOff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vfQ    <= '0;
      gpaQ   <= '0;
      baseQ  <= '0;
      hpaQ   <= '0;
      faultQ <= 1'b0;
      codeQ  <= FC_NONE;
    end else begin
      if (ctl.capture) begin
        vfQ    <= reqVfId;
        gpaQ   <= reqGpa;
        baseQ  <= dirBase;
        hpaQ   <= '0;
        faultQ <= 1'b0;
        codeQ  <= FC_NONE;
      end
      if (ctl.loadPtr)  baseQ <= nextBase;
      if (ctl.loadLeaf) hpaQ  <= leafHpa;
      if (ctl.setFault) begin
        faultQ <= 1'b1;
        codeQ  <= ctl.code;
      end
    end
  end

  assign rspFault = faultQ;
  assign rspCode  = codeQ;
  assign rspHpa   = hpaQ;

  // R5: leaf entry addresses are 4-byte aligned, upper levels 8-byte aligned
  a_r5_entry_align: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.loadPtr |=> (memAddr[1:0] == 2'b00));

endmodule

// File: rtl/vf_xlat_ctrl.sv
module vf_xlat_ctrl
  import xw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     reqValid,
  input  logic     vfBad,
  input  logic     memReady,
  input  logic     memRdValid,
  input  logic     entryValid,
  output logic     reqReady,
  output logic     memReq,
  output logic     rspValid,
  output walkCtl_t ctl
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESP} state_e;

  state_e     stateQ, stateD;
  logic [1:0] levelQ, levelD;

  always_comb begin
    stateD       = stateQ;
    levelD       = levelQ;
    ctl          = '0;
    ctl.code     = FC_NONE;
    ctl.level    = levelQ;
    reqReady     = 1'b0;
    memReq       = 1'b0;
    rspValid     = 1'b0;
    unique case (stateQ)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.capture = 1'b1;
          if (vfBad) begin
            ctl.setFault = 1'b1;
            ctl.code     = FC_BAD_VF;
            stateD       = S_RESP;
          end else begin
            levelD = LVL_DIR;
            stateD = S_ISSUE;
          end
        end
      end
      S_ISSUE: begin
        memReq = 1'b1;
        if (memReady) stateD = S_WAIT;
      end
      S_WAIT: begin
        if (memRdValid) begin
          if (!entryValid) begin
            ctl.setFault = 1'b1;
            unique case (levelQ)
              LVL_DIR: ctl.code = FC_DIR;
              LVL_MID: ctl.code = FC_MID;
              default: ctl.code = FC_LEAF;
            endcase
            stateD = S_RESP;
          end else if (levelQ == LVL_LEAF) begin
            ctl.loadLeaf = 1'b1;
            stateD       = S_RESP;
          end else begin
            ctl.loadPtr = 1'b1;
            levelD      = levelQ - 2'd1;
            stateD      = S_ISSUE;
          end
        end
      end
      default: begin
        rspValid = 1'b1;
        stateD   = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= S_IDLE;
      levelQ <= LVL_DIR;
    end else begin
      stateQ <= stateD;
      levelQ <= levelD;
    end
  end

  // R2: a rejected function number never produces a read
  a_r2_badvf_noread: assert property (@(posedge clk) disable iff (!rst_n)
    (reqReady && reqValid && vfBad) |=> !memReq);

  // R7: only one read outstanding; data never arrives while a request is open
  a_r7_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    memRdValid |-> !memReq);

endmodule

// File: rtl/vf_xlat_walker.sv
module vf_xlat_walker
  import xw_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int VFID_W = 8,
  parameter int NUM_FN = 64,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] dirBase,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VFID_W-1:0] reqVfId,
  input  logic [ADDR_W-1:0] reqGpa,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memReady,
  input  logic              memRdValid,
  input  logic [DATA_W-1:0] memRdData,
  output logic              rspValid,
  output logic              rspFault,
  output logic [2:0]        rspCode,
  output logic [ADDR_W-1:0] rspHpa
);

  walkCtl_t ctl;
  logic     vfBad;
  logic     entryValid;

  vf_xlat_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .vfBad      (vfBad),
    .memReady   (memReady),
    .memRdValid (memRdValid),
    .entryValid (entryValid),
    .reqReady   (reqReady),
    .memReq     (memReq),
    .rspValid   (rspValid),
    .ctl        (ctl)
  );

  vf_xlat_dp #(
    .ADDR_W (ADDR_W),
    .VFID_W (VFID_W),
    .NUM_FN (NUM_FN),
    .DATA_W (DATA_W)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .dirBase    (dirBase),
    .reqVfId    (reqVfId),
    .reqGpa     (reqGpa),
    .memRdData  (memRdData),
    .vfBad      (vfBad),
    .entryValid (entryValid),
    .memAddr    (memAddr),
    .rspFault   (rspFault),
    .rspCode    (rspCode),
    .rspHpa     (rspHpa)
  );

  // R7: an unaccepted read keeps its request and address
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memReady) |=> (memReq && $stable(memAddr)));

  // R8: accepting a request makes the walker busy
  a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> !reqReady);

  // R8: the response lasts one cycle and the walker is free again afterwards
  a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |=> (!rspValid && reqReady));

  // R6: a successful response carries code zero
  a_r6_ok_code: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && !rspFault) |-> (rspCode == 3'd0));

  // R2: a fault response never carries code zero
  a_r2_fault_code: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspFault) |-> (rspCode != 3'd0));

endmodule

// File: tb/vf_xlat_walker_tb.sv
module vf_xlat_walker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] dirBase = 48'h0000_1000_0000;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [7:0]  reqVfId = '0;
  logic [47:0] reqGpa = '0;
  logic        memReq;
  logic [47:0] memAddr;
  logic        memReady;
  logic        memRdValid;
  logic [63:0] memRdData;
  logic        rspValid;
  logic        rspFault;
  logic [2:0]  rspCode;
  logic [47:0] rspHpa;

  always #5 clk = ~clk;

  vf_xlat_walker dut_i (
    .clk(clk), .rst_n(rst_n), .dirBase(dirBase),
    .reqValid(reqValid), .reqReady(reqReady), .reqVfId(reqVfId), .reqGpa(reqGpa),
    .memReq(memReq), .memAddr(memAddr), .memReady(memReady),
    .memRdValid(memRdValid), .memRdData(memRdData),
    .rspValid(rspValid), .rspFault(rspFault), .rspCode(rspCode), .rspHpa(rspHpa)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [63:0] mem [logic [47:0]];
  int          readCount = 0;
  bit          stallEn = 1'b0;

  function automatic logic [63:0] lookup(input logic [47:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'h0;
  endfunction

  initial begin
    logic [47:0] pendAddr;
    bit          havePend;
    int          stallCnt;
    havePend   = 1'b0;
    stallCnt   = 0;
    pendAddr   = '0;
    memRdValid = 1'b0;
    memRdData  = '0;
    memReady   = 1'b1;
    forever begin
      @(posedge clk);
      memRdValid <= 1'b0;
      if (havePend) begin
        memRdValid <= 1'b1;
        memRdData  <= lookup(pendAddr);
        havePend = 1'b0;
      end
      if (memReq && memReady) begin
        pendAddr = memAddr;
        havePend = 1'b1;
        readCount++;
      end
      stallCnt++;
      memReady <= !stallEn || (stallCnt % 4 == 3);
    end
  end

  // hold monitor for R7
  int  holdViol = 0;
  int  stallSeen = 0;
  initial begin
    bit          prevPend;
    logic [47:0] prevAddr;
    prevPend = 1'b0;
    prevAddr = '0;
    forever begin
      @(negedge clk);
      if (prevPend && (!memReq || memAddr != prevAddr)) holdViol++;
      prevPend = rst_n && memReq && !memReady;
      if (prevPend) stallSeen++;
      prevAddr = memAddr;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- vectors ----------------
  typedef struct packed {
    logic [7:0]  vf;
    logic [47:0] gpa;
    logic        fault;
    logic [2:0]  code;
    logic [47:0] hpa;
    logic [3:0]  reads;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'd3,   48'h0008_0041_2345, 1'b0, 3'd0, 48'h0003_5781_2345, 4'd3}, // R6 mid indices
    '{8'd3,   48'hFFFF_FFFF_FFFF, 1'b0, 3'd0, 48'h8000_003F_FFFF, 4'd3}, // R4 R5 all-ones indices
    '{8'd5,   48'h0000_0000_0ABC, 1'b1, 3'd3, 48'h0,              4'd2}, // R4 mid invalid
    '{8'd63,  48'h0010_00A0_0000, 1'b1, 3'd4, 48'h0,              4'd3}, // R5 leaf invalid
    '{8'd0,   48'h0008_0041_2345, 1'b1, 3'd1, 48'h0,              4'd0}, // R2 function 0
    '{8'd64,  48'h0008_0041_2345, 1'b1, 3'd1, 48'h0,              4'd0}, // R2 function 64
    '{8'd7,   48'h0008_0041_2345, 1'b1, 3'd2, 48'h0,              4'd1}, // R3 directory invalid
    '{8'd5,   48'h0018_201F_0000, 1'b0, 3'd0, 48'h0000_00BF_0000, 4'd3}, // R6 second function
    '{8'd200, 48'h0000_0000_0000, 1'b1, 3'd1, 48'h0,              4'd0}  // R2 large number
  };

  task automatic walk(input logic [7:0] vf, input logic [47:0] gpa, input bit junk,
                      output logic f, output logic [2:0] c, output logic [47:0] h,
                      output int reads);
    int start;
    @(negedge clk);
    reqVfId  = vf;
    reqGpa   = gpa;
    reqValid = 1'b1;
    start    = readCount;
    @(negedge clk);
    check(!reqReady, "R8", "busy after accept", 64'(reqReady), 64'd0);
    if (junk) begin
      reqVfId = 8'd0;
      reqGpa  = 48'h1234_5678_9ABC;
    end else begin
      reqValid = 1'b0;
    end
    while (!rspValid) begin
      if (reqReady) check(1'b0, "R8", "ready during walk", 64'd1, 64'd0);
      @(negedge clk);
    end
    f = rspFault;
    c = rspCode;
    h = rspHpa;
    reads = readCount - start;
    reqValid = 1'b0;
    @(negedge clk);
    check(!rspValid && reqReady, "R8", "pulse end and ready",
          64'({rspValid, reqReady}), 64'b01);
  endtask

  initial begin
    logic        f;
    logic [2:0]  c;
    logic [47:0] h;
    int          reads;

    // directory (reserved bits 3:1 set on function 3)
    mem[48'h0000_1000_0000] = 64'hA001;             // function 0, must never be read
    mem[48'h0000_1000_0200] = 64'hA001;             // function 64, must never be read
    mem[48'h0000_1000_0018] = 64'h200F;             // fn 3 -> 0x0200_0000
    mem[48'h0000_1000_0028] = 64'h3001;             // fn 5 -> 0x0300_0000
    mem[48'h0000_1000_01F8] = 64'h4001;             // fn 63 -> 0x0400_0000
    mem[48'h0000_1000_0038] = 64'h5000;             // fn 7 invalid
    // mid level
    mem[48'h0000_0200_0008] = 64'h6001;
    mem[48'h0000_0200_FFF8] = 64'hFFFF_FFF0_0000_7001;
    mem[48'h0000_0400_0010] = 64'h8001;
    mem[48'h0000_0300_0018] = 64'h9001;
    // leaves with junk in the upper half
    mem[48'h0000_0600_0008] = 64'hDEAD_BEEF_0003_579F;
    mem[48'h0000_0700_FFFC] = 64'hDEAD_BEEF_8000_0021;
    mem[48'h0000_0900_0400] = 64'hDEAD_BEEF_0000_00A1;

    repeat (3) @(negedge clk);
    check(reqReady && !memReq && !rspValid, "R1", "reset outputs",
          64'({reqReady, memReq, rspValid}), 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(reqReady && !memReq && !rspValid, "R1", "idle after reset",
          64'({reqReady, memReq, rspValid}), 64'b100);

    for (int i = 0; i < NV; i++) begin
      walk(VECS[i].vf, VECS[i].gpa, 1'b0, f, c, h, reads);
      check(f == VECS[i].fault, "R2-R6 vec", "fault", 64'(f), 64'(VECS[i].fault));
      check(c == VECS[i].code, "R2-R6 vec", "code", 64'(c), 64'(VECS[i].code));
      check(h == VECS[i].hpa, "R6 vec", "hpa", 64'(h), 64'(VECS[i].hpa));
      check(reads == int'(VECS[i].reads), "R3 vec", "read count",
            64'(reads), 64'(VECS[i].reads));
    end

    // R7 and R8: stalled memory, request inputs changed during the walk
    stallEn = 1'b1;
    walk(8'd3, 48'h0008_0041_2345, 1'b1, f, c, h, reads);
    check(!f && h == 48'h0003_5781_2345, "R8", "result under changed inputs",
          64'(h), 64'h0003_5781_2345);
    check(reads == 3, "R7", "reads under stall", 64'(reads), 64'd3);
    check(stallSeen > 0, "R7", "stall exercised", 64'(stallSeen), 64'd1);
    check(holdViol == 0, "R7", "request hold", 64'(holdViol), 64'd0);
    stallEn = 1'b0;

    // back-to-back fault then success
    walk(8'd64, 48'h0, 1'b0, f, c, h, reads);
    check(f && c == 3'd1 && reads == 0, "R2", "bad function after stall",
          64'(c), 64'd1);
    walk(8'd5, 48'h0018_201F_0000, 1'b0, f, c, h, reads);
    check(!f && h == 48'h0000_00BF_0000, "R6", "walk after fault",
          64'(h), 64'h0000_00BF_0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule